// File: doc/BRIEF.md
# Output Voltage Setpoint Sequencer

This block sits between a register write port and the reference DAC of a step-down regulator. Software writes a 6-bit voltage code, a 2-bit slew selection and a GO control bit. Writing the code alone does nothing. When GO goes from 0 to 1, the block captures the code held at that moment as its target, clamping it to 48. It then walks its DAC code output toward that target one LSB at a time. One code step is about 15 mV, so codes 0 to 48 cover roughly 0.85 V to 1.55 V.

The pace comes from a slow step-enable strobe (`step_tick`) supplied by the chip. The slew field sets how many strobes pass between consecutive code steps. While the output walks toward its target, `busy` is high. A single-cycle `done` pulse marks arrival. A new GO edge during a ramp retargets it from the present code, so the output never jumps.

The write port is a valid/ready stream. `wr_ready` is held high, so the port never applies back-pressure, and every cycle with `wr_valid` high commits one write.

Top module: `vseq_top`

## Requirements
- R1: After reset, `dac_code` is 0, `busy` and `done` are 0, and the code, slew and GO registers are 0.
- R2: Register map, with a write taking effect on the clock edge where `wr_valid` is high:
  - address 0, bits [5:0] hold the voltage code;
  - address 1, bits [1:0] hold the slew field;
  - address 2, bit 0 holds GO.
  - `wr_ready` is always 1.
- R3: Writing the code register without a GO edge leaves `dac_code` and `busy` unchanged.
- R4: A target is captured only when a GO write changes GO from 0 to 1. Writing GO=1 while GO is already 1, or writing GO=0, starts nothing.
- R5: The target is the code held just before the GO edge. Code writes made after the edge do not change the ramp's end point.
- R6: A captured code above 48 is treated as 48, so `dac_code` never exceeds 48.
- R7: `dac_code` changes by exactly one LSB per step. Steps move toward the target, upward or downward.
- R8: Slew field values 0, 1, 2 and 3 place a step on every 1st, 2nd, 4th and 8th `step_tick` counted since the GO edge.
- R9: `busy` rises in the cycle after the GO edge and stays high through the cycle in which `dac_code` first equals the target. In the next cycle `busy` is 0 and `done` is 1 for exactly one cycle.
- R10: A GO edge during a ramp keeps `dac_code` at its present value, restarts the step count, and ramps to the new target from there.
- R11: A GO edge whose target equals the present `dac_code` gives one cycle of `busy`, followed by the one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| step_tick | input | 1 | Slow step-enable strobe |
| dac_code | output | 6 | Present DAC code |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle arrival pulse |

## Verification
The hardest state to reach is a retarget in the middle of a ramp. To get there, the stimulus lets a ramp advance a known number of strobes and then rewrites the code. It then toggles GO back to 0 and up to 1 while `busy` is still high. The new end point lies below the present output, so the reversed direction and the absence of a jump are both visible. A second awkward case is a GO edge whose target equals the present output. It is reached by re-arming GO with an unchanged code right after an arrival.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int unsigned ADR_CODE = 0;
  localparam int unsigned ADR_SLEW = 1;
  localparam int unsigned ADR_GO   = 2;
endpackage

// File: rtl/vseq_regs.sv
module vseq_regs #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned CODE_MAX = 48,
  parameter int unsigned SLEW_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              load_o,
  output logic [CODE_W-1:0] load_code_o,
  output logic [SLEW_W-1:0] slew_o
);
  import vseq_pkg::*;

  localparam logic [CODE_W-1:0] CLAMP = CODE_W'(CODE_MAX);

  logic [CODE_W-1:0] code_q;
  logic [SLEW_W-1:0] slew_q;
  logic              go_q;
  logic              go_wr;

  assign go_wr       = wr_valid && (wr_addr == ADDR_W'(ADR_GO));
  assign load_o      = go_wr && wr_data[0] && !go_q;
  assign load_code_o = (code_q > CLAMP) ? CLAMP : code_q;
  assign slew_o      = slew_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      slew_q <= '0;
      go_q   <= 1'b0;
    end else if (wr_valid) begin
      if (wr_addr == ADDR_W'(ADR_CODE)) code_q <= wr_data[CODE_W-1:0];
      if (wr_addr == ADDR_W'(ADR_SLEW)) slew_q <= wr_data[SLEW_W-1:0];
      if (go_wr)                        go_q   <= wr_data[0];
    end
  end

  // R4
  go_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> go_q);

  // R6
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (load_code_o <= CLAMP));
endmodule

// File: rtl/vseq_pacer.sv
module vseq_pacer #(
  parameter int unsigned SLEW_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [SLEW_W-1:0] slew_i,
  output logic              step_o
);
  localparam int unsigned CNT_W = (1 << SLEW_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'((1 << slew_i) - 1);
  assign step_o = run_i && tick_i && !clear_i && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
    end
  end

  // R8
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (tick_i && run_i));
endmodule

// File: rtl/vseq_ramp.sv
module vseq_ramp #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned CODE_MAX = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_code_i,
  input  logic              step_i,
  output logic              run_o,
  output logic [CODE_W-1:0] dac_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [CODE_W-1:0] dac_q;
  logic [CODE_W-1:0] tgt_q;
  logic              busy_q;
  logic              done_q;
  logic              at_tgt;

  assign at_tgt = (dac_q == tgt_q);
  assign run_o  = busy_q && !at_tgt;
  assign dac_o  = dac_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= '0;
      tgt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      tgt_q  <= load_code_i;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && at_tgt) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (busy_q && step_i) begin
        dac_q <= (tgt_q > dac_q) ? dac_q + 1'b1 : dac_q - 1'b1;
      end
    end
  end

  // R6
  dac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_q <= CODE_W'(CODE_MAX));

  // R7
  single_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_q) |-> ((dac_q == $past(dac_q) + 1'b1) || (dac_q == $past(dac_q) - 1'b1)));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // R3
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(tgt_q));

  // R10
  no_jump_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> $stable(dac_q));
endmodule

// File: rtl/vseq_top.sv
module vseq_top #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned CODE_MAX = 48,
  parameter int unsigned SLEW_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step_tick,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              done
);
  logic              load;
  logic [CODE_W-1:0] load_code;
  logic [SLEW_W-1:0] slew;
  logic              run;
  logic              step;

  assign wr_ready = 1'b1;

  vseq_regs #(
    .CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .SLEW_W(SLEW_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_o(load), .load_code_o(load_code), .slew_o(slew)
  );

  vseq_pacer #(.SLEW_W(SLEW_W)) pacer_i (
    .clk(clk), .rst_n(rst_n), .clear_i(load), .run_i(run),
    .tick_i(step_tick), .slew_i(slew), .step_o(step)
  );

  vseq_ramp #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) ramp_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_code_i(load_code),
    .step_i(step), .run_o(run), .dac_o(dac_code), .busy_o(busy), .done_o(done)
  );
endmodule

// File: tb/vseq_top_tb_top.sv
module vseq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       step_tick = 1'b0;
  logic [5:0] dac_code;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .step_tick(step_tick),
    .dac_code(dac_code), .busy(busy), .done(done)
  );

  localparam int NV = 6;
  localparam int V_SLEW [NV] = '{0, 1, 2, 3, 0, 0};
  localparam int V_CODE [NV] = '{5, 2, 63, 40, 49, 0};
  localparam int V_EXP  [NV] = '{5, 2, 48, 40, 48, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick();
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
  endtask

  // Drives strobes until arrival, checking step spacing and direction (R7, R8),
  // end point and the busy/done handshake (R9).
  task automatic ramp_run(input int exp_tgt, input int slew, input string req);
    int prev = int'(dac_code);
    int n = 0;
    bit bad = 0;
    int iv = 1 << slew;
    int bad_act = 0;
    while (int'(dac_code) != exp_tgt && n < 1000) begin
      tick();
      n++;
      if ((n % iv) == 0) begin
        if (int'(dac_code) != prev + ((exp_tgt > prev) ? 1 : -1)) begin bad = 1; bad_act = int'(dac_code); end
      end else if (int'(dac_code) != prev) begin
        bad = 1; bad_act = int'(dac_code);
      end
      prev = int'(dac_code);
    end
    check(!bad, {req, " R7 R8 step pattern"}, bad_act, prev);
    check(int'(dac_code) == exp_tgt, {req, " final code"}, int'(dac_code), exp_tgt);
    check(busy == 1'b1, "R9 busy through arrival cycle", int'(busy), 1);
    @(negedge clk);
    check(!busy && done, "R9 done after arrival", {busy, done}, 1);
    @(negedge clk);
    check(!done, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dac_code == 0 && !busy && !done, "R1 reset outputs", {dac_code, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_code == 0 && !busy && !done, "R1 idle after reset", {dac_code, busy, done}, 0);
    check(wr_ready == 1'b1, "R2 wr_ready", int'(wr_ready), 1);

    // Table-driven ramps: R2, R6, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      wr(1, V_SLEW[i]);
      wr(0, V_CODE[i]);
      wr(2, 0);
      wr(2, 1);
      check(busy == 1'b1, "R9 busy after GO edge", int'(busy), 1);
      ramp_run(V_EXP[i], V_SLEW[i], (V_CODE[i] > 48) ? "R6 R2 clamp" : "R2 table");
    end

    // R3 code write alone
    wr(0, 10);
    tick(); tick(); tick();
    check(dac_code == 0 && !busy, "R3 code write alone", int'(dac_code), 0);
    // R4 GO 1->0 does nothing
    wr(2, 0);
    tick(); tick();
    check(dac_code == 0 && !busy, "R4 GO falling", int'(dac_code), 0);

    // R5 later code write ignored
    wr(2, 1);
    tick(); tick();
    check(dac_code == 2, "R5 mid-ramp code", int'(dac_code), 2);
    wr(0, 30);
    ramp_run(10, 0, "R5 target kept");

    // R4 GO written 1 while already 1
    wr(2, 1);
    tick(); tick(); tick();
    check(dac_code == 10 && !busy, "R4 GO held high", int'(dac_code), 10);

    // R10 retarget mid-ramp, downward
    wr(2, 0);
    wr(2, 1);
    tick(); tick(); tick();
    check(dac_code == 13 && busy, "R10 ramp before retarget", int'(dac_code), 13);
    wr(0, 11);
    wr(2, 0);
    wr(2, 1);
    check(dac_code == 13 && busy, "R10 no jump on retarget", int'(dac_code), 13);
    ramp_run(11, 0, "R10 retarget down");

    // R11 equal target
    wr(2, 0);
    wr(2, 1);
    check(busy && !done && dac_code == 11, "R11 busy one cycle", {busy, done}, 2);
    @(negedge clk);
    check(!busy && done, "R11 done pulse", {busy, done}, 1);
    @(negedge clk);
    check(!done && dac_code == 11, "R11 done ends", int'(done), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule